// File: doc/BRIEF.md
# Flash Busy-Status Toggle Generator

This block is the device-side status logic of a simplified flash memory model. When the command logic accepts a program or erase command, the block enters a busy phase. During that phase every completed read cycle inverts bit 6 of the returned byte, and bit 5 reports an internal failure. Software can poll any address, see bit 6 change between two reads, and conclude that the embedded operation is still running. Once the operation finishes, reads return plain array data again.

Two protection cases are handled locally. A program command whose target sector is locked, or an erase command whose selected sectors are all locked, starts no operation. The block still shows busy for a fixed window, counted in clock cycles, before it returns to array reads. The two window lengths are parameters, so simulation can shrink them. An erase that touches at least one unlocked sector runs as a normal operation. Skipping the locked sectors belongs to the erase engine. A failure reported while busy keeps the block busy, with bit 5 high and bit 6 still toggling, until a reset command arrives.

Top module: `flash_toggle_status`

## Requirements
- R1: While idle, `busy` is 0 and `dataOut` equals `arrayData` on every bit, whether or not a read is in progress.
- R2: A `progStart` or `eraseStart` pulse accepted while idle raises `busy` from the next clock. If `sectorsLocked` is 0, the operation is a normal one. The first read after acceptance returns bit 6 = 0.
- R3: While busy, each completed read cycle inverts bit 6 (`dataOut[6]`) of the value seen on the next read. The value stays constant during a read.
- R4: A read cycle is the interval in which `oeN` and `ceN` are both low. It completes when either one rises. Pulsing `oeN` with `ceN` held low counts as a read, and so does pulsing `ceN` with `oeN` held low.
- R5: In a normal operation, an `opDone` pulse returns the block to idle on the next clock. From then on `dataOut` equals `arrayData`.
- R6: A program accepted with `sectorsLocked` = 1 keeps `busy` high for exactly `PROG_WIN` clocks after the accepting edge and then goes idle. `opDone` has no effect during this window.
- R7: An erase accepted with `sectorsLocked` = 1 keeps `busy` high for exactly `ERASE_WIN` clocks. Bit 6 keeps toggling on reads throughout the window.
- R8: An `opFail` pulse during a normal operation sets bit 5 (`dataOut[5]`) to 1. The block then stays busy with bit 5 high and bit 6 toggling, and ignores `opDone`, until a `resetCmd` pulse returns it to idle.
- R9: While busy without failure, bit 5 reads 0. All bits other than 5 and 6 follow `arrayData`.
- R10: While busy and not failed, `progStart`, `eraseStart` and `resetCmd` are ignored. They neither clear bit 6 nor end or restart the busy phase or window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progStart | input | 1 | Program command accepted (one-cycle pulse) |
| eraseStart | input | 1 | Erase command accepted (one-cycle pulse) |
| sectorsLocked | input | 1 | Program target locked, or all erase sectors locked; sampled with the start pulse |
| opDone | input | 1 | Embedded operation finished |
| opFail | input | 1 | Embedded operation failed |
| resetCmd | input | 1 | Reset command decoded |
| oeN | input | 1 | Output enable, active low |
| ceN | input | 1 | Chip enable, active low |
| arrayData | input | DATA_W | Data read from the array |
| dataOut | output | DATA_W | Data returned to the bus |
| busy | output | 1 | Embedded or locked-window phase in progress |

## Verification
The bench reads with `oeN` pulses and, separately, with `ceN` pulses. A design that advanced the toggle on only one strobe would return the same bit 6 twice in a row. Both locked windows are probed one clock before and one clock after their predicted end, so an off-by-one counter shows up as a wrong `busy`. In the same windows, stray `opDone` and start pulses would otherwise end or reload the window early. The failure path checks that bit 5 stays set and that `opDone` is ignored until `resetCmd` arrives. A reset command issued during a normal operation must not clear the toggle. A design that restarted or aborted on it would show a stale bit 6 or drop `busy`.

// File: rtl/flash_tog_pkg.sv
package flash_tog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_LOCKED = 2'd2,
    ST_FAULT  = 2'd3
  } togState_t;

  typedef struct packed {
    logic togClr;
    logic togAdv;
    logic failSet;
    logic failClr;
    logic loadProg;
    logic loadErase;
    logic winRun;
  } togStrb_t;

endpackage

// File: rtl/tog_read_detect.sv
module tog_read_detect (
  input  logic clk,
  input  logic rstN,
  input  logic oeN,
  input  logic ceN,
  output logic readEnd
);

  logic readActive;
  logic readActiveQ;

  assign readActive = !oeN && !ceN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readActiveQ <= 1'b0;
    else       readActiveQ <= readActive;
  end

  // a read completes when either strobe rises
  assign readEnd = readActiveQ && !readActive;

endmodule

// File: rtl/tog_ctrl.sv
module tog_ctrl
  import flash_tog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      progStart,
  input  logic      eraseStart,
  input  logic      sectorsLocked,
  input  logic      opDone,
  input  logic      opFail,
  input  logic      resetCmd,
  input  logic      readEnd,
  input  logic      winZero,
  output togStrb_t  strb,
  output togState_t state
);

  togState_t stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (progStart || eraseStart) begin
          strb.togClr  = 1'b1;
          strb.failClr = 1'b1;
          if (sectorsLocked) begin
            stateNxt = ST_LOCKED;
            if (eraseStart) strb.loadErase = 1'b1;
            else            strb.loadProg  = 1'b1;
          end else begin
            stateNxt = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strb.togAdv = readEnd;
        if (opFail) begin
          stateNxt     = ST_FAULT;
          strb.failSet = 1'b1;
        end else if (opDone) begin
          stateNxt = ST_IDLE;
        end
      end
      ST_LOCKED: begin
        strb.togAdv = readEnd;
        strb.winRun = 1'b1;
        if (winZero) stateNxt = ST_IDLE;
      end
      ST_FAULT: begin
        strb.togAdv = readEnd;
        if (resetCmd) begin
          stateNxt     = ST_IDLE;
          strb.failClr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && (progStart || eraseStart)) |=> (state != ST_IDLE)); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && !winZero) |=> (state == ST_LOCKED)); // R6
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT && !resetCmd) |=> (state == ST_FAULT)); // R8
  AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !opDone && !opFail) |=> (state == ST_RUN)); // R10

endmodule

// File: rtl/tog_datapath.sv
module tog_datapath
  import flash_tog_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PROG_WIN  = 200000,
  parameter int ERASE_WIN = 10000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  togStrb_t          strb,
  input  logic              busy,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              winZero
);

  localparam int WIN_MAX  = (ERASE_WIN > PROG_WIN) ? ERASE_WIN : PROG_WIN;
  localparam int CNT_W    = (WIN_MAX > 2) ? $clog2(WIN_MAX) : 1;
  localparam int TOG_POS  = 6;
  localparam int FAIL_POS = 5;

  logic             togBit;
  logic             failBit;
  logic [CNT_W-1:0] winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            togBit <= 1'b0;
    else if (strb.togClr) togBit <= 1'b0;
    else if (strb.togAdv) togBit <= ~togBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             failBit <= 1'b0;
    else if (strb.failClr) failBit <= 1'b0;
    else if (strb.failSet) failBit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         winCnt <= '0;
    else if (strb.loadProg)            winCnt <= CNT_W'(PROG_WIN - 1);
    else if (strb.loadErase)           winCnt <= CNT_W'(ERASE_WIN - 1);
    else if (strb.winRun && !winZero)  winCnt <= winCnt - 1'b1;
  end

  assign winZero = (winCnt == '0);

  for (genvar g = 0; g < DATA_W; g++) begin : gOut
    if (g == TOG_POS) begin : gTog
      assign dataOut[g] = busy ? togBit : arrayData[g];
    end else if (g == FAIL_POS) begin : gFail
      assign dataOut[g] = busy ? failBit : arrayData[g];
    end else begin : gPass
      assign dataOut[g] = arrayData[g];
    end
  end

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.togAdv && !strb.togClr) |=> (togBit != $past(togBit))); // R3
  AST_WIN_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winRun && !winZero && !strb.loadProg && !strb.loadErase)
      |=> (winCnt == $past(winCnt) - 1'b1)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failBit && !strb.failClr) |=> failBit); // R8

endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
  import flash_tog_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PROG_WIN  = 200000,
  parameter int ERASE_WIN = 10000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progStart,
  input  logic              eraseStart,
  input  logic              sectorsLocked,
  input  logic              opDone,
  input  logic              opFail,
  input  logic              resetCmd,
  input  logic              oeN,
  input  logic              ceN,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              busy
);

  togStrb_t  strb;
  togState_t state;
  logic      readEnd;
  logic      winZero;

  tog_read_detect uRead (
    .clk     (clk),
    .rstN    (rstN),
    .oeN     (oeN),
    .ceN     (ceN),
    .readEnd (readEnd)
  );

  tog_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .progStart     (progStart),
    .eraseStart    (eraseStart),
    .sectorsLocked (sectorsLocked),
    .opDone        (opDone),
    .opFail        (opFail),
    .resetCmd      (resetCmd),
    .readEnd       (readEnd),
    .winZero       (winZero),
    .strb          (strb),
    .state         (state)
  );

  assign busy = (state != ST_IDLE);

  tog_datapath #(
    .DATA_W    (DATA_W),
    .PROG_WIN  (PROG_WIN),
    .ERASE_WIN (ERASE_WIN)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .arrayData (arrayData),
    .dataOut   (dataOut),
    .winZero   (winZero)
  );

endmodule

// File: tb/sim_flash_toggle_status.sv
module sim_flash_toggle_status;

  localparam int DW = 8;
  localparam int PW = 20;
  localparam int EW = 50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          progStart = 1'b0, eraseStart = 1'b0, sectorsLocked = 1'b0;
  logic          opDone = 1'b0, opFail = 1'b0, resetCmd = 1'b0;
  logic          oeN = 1'b1, ceN = 1'b0;
  logic [DW-1:0] arrayData = 8'hA5;
  logic [DW-1:0] dataOut;
  logic          busy;

  flash_toggle_status #(.DATA_W(DW), .PROG_WIN(PW), .ERASE_WIN(EW)) u0 (
    .clk(clk), .rstN(rstN), .progStart(progStart), .eraseStart(eraseStart),
    .sectorsLocked(sectorsLocked), .opDone(opDone), .opFail(opFail),
    .resetCmd(resetCmd), .oeN(oeN), .ceN(ceN), .arrayData(arrayData),
    .dataOut(dataOut), .busy(busy)
  );

  typedef struct {
    string         req;
    logic [DW-1:0] expData;
    logic          expBusy;
  } item_t;

  item_t sbq[$];
  event  sampleEv;
  int    nCmp = 0;
  int    nBad = 0;
  bit    finished = 1'b0;

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        nCmp++;
        if (dataOut !== it.expData || busy !== it.expBusy) begin
          nBad++;
          $display("FAIL %s: dataOut=%h busy=%b expected dataOut=%h busy=%b",
                   it.req, dataOut, busy, it.expData, it.expBusy);
        end
      end
    end
  end

  function automatic logic [DW-1:0] stat(logic [DW-1:0] arr, logic tog, logic fl);
    logic [DW-1:0] r;
    r    = arr;
    r[6] = tog;
    r[5] = fl;
    return r;
  endfunction

  task automatic expectNow(string req, logic [DW-1:0] d, logic b);
    sbq.push_back('{req, d, b});
    ->sampleEv;
    #1;
  endtask

  // one read framed by oeN (useCe=0, ceN held low) or by ceN (useCe=1, oeN held low)
  task automatic readCycle(bit useCe, string req, logic [DW-1:0] d, logic b);
    if (useCe) ceN = 1'b0; else oeN = 1'b0;
    @(negedge clk);
    expectNow(req, d, b);
    if (useCe) ceN = 1'b1; else oeN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 idle pass-through
    expectNow("R1", 8'hA5, 1'b0);
    readCycle(1'b0, "R1", 8'hA5, 1'b0);

    // R2 normal program
    progStart = 1'b1;
    @(negedge clk);
    progStart = 1'b0;
    expectNow("R2", stat(8'hA5, 1'b0, 1'b0), 1'b1);
    readCycle(1'b0, "R2", stat(8'hA5, 1'b0, 1'b0), 1'b1);

    // R4 reads framed by chip enable
    oeN = 1'b0; ceN = 1'b1;
    readCycle(1'b1, "R4", stat(8'hA5, 1'b1, 1'b0), 1'b1);
    readCycle(1'b1, "R3", stat(8'hA5, 1'b0, 1'b0), 1'b1);
    ceN = 1'b0; oeN = 1'b1;

    // R9 other bits follow the array
    arrayData = 8'h3C;
    expectNow("R9", stat(8'h3C, 1'b1, 1'b0), 1'b1);

    // R10 starts and reset ignored while running
    resetCmd = 1'b1; progStart = 1'b1;
    @(negedge clk);
    resetCmd = 1'b0; progStart = 1'b0;
    expectNow("R10", stat(8'h3C, 1'b1, 1'b0), 1'b1);
    readCycle(1'b0, "R10", stat(8'h3C, 1'b1, 1'b0), 1'b1);

    // R5 completion
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
    expectNow("R5", 8'h3C, 1'b0);
    readCycle(1'b0, "R5", 8'h3C, 1'b0);

    // R8 failure path
    arrayData = 8'h00;
    eraseStart = 1'b1;
    @(negedge clk);
    eraseStart = 1'b0; opFail = 1'b1;
    @(negedge clk);
    opFail = 1'b0;
    expectNow("R8", stat(8'h00, 1'b0, 1'b1), 1'b1);
    readCycle(1'b0, "R8", stat(8'h00, 1'b0, 1'b1), 1'b1);
    readCycle(1'b0, "R8", stat(8'h00, 1'b1, 1'b1), 1'b1);
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
    expectNow("R8", stat(8'h00, 1'b0, 1'b1), 1'b1);
    readCycle(1'b0, "R8", stat(8'h00, 1'b0, 1'b1), 1'b1);
    resetCmd = 1'b1;
    @(negedge clk);
    resetCmd = 1'b0;
    expectNow("R8", 8'h00, 1'b0);

    // R6 locked program window with stray done/start pulses
    arrayData = 8'hA5;
    sectorsLocked = 1'b1;
    progStart = 1'b1;
    @(negedge clk);
    progStart = 1'b0; opDone = 1'b1; eraseStart = 1'b1;
    @(negedge clk);
    opDone = 1'b0; eraseStart = 1'b0;
    repeat (PW - 2) @(negedge clk);
    expectNow("R6", stat(8'hA5, 1'b0, 1'b0), 1'b1);
    @(negedge clk);
    expectNow("R6", 8'hA5, 1'b0);

    // R7 locked erase window with toggling reads
    eraseStart = 1'b1;
    @(negedge clk);
    eraseStart = 1'b0;
    readCycle(1'b0, "R7", stat(8'hA5, 1'b0, 1'b0), 1'b1);
    readCycle(1'b0, "R7", stat(8'hA5, 1'b1, 1'b0), 1'b1);
    repeat (EW - 5) @(negedge clk);
    expectNow("R7", stat(8'hA5, 1'b0, 1'b0), 1'b1);
    @(negedge clk);
    expectNow("R7", 8'hA5, 1'b0);
    sectorsLocked = 1'b0;

    #20;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule